// File: doc/BRIEF.md
# Dual Halfword Signed Multiply-Accumulate Unit

This unit treats each of two 32-bit operands as a packed pair of signed 16-bit halfwords. The low halfword is bits 15:0 and the high halfword is bits 31:16. It forms two full-precision signed 16x16 products. Before multiplying, the halfwords of the second operand may be swapped, so the low half of the first operand meets the high half of the second, and the reverse.

The two products are then combined. In sum mode they are added. In difference mode the high-lane product is taken away from the low-lane product. The 32-bit result appears one clock after the request, and a new request can be accepted every cycle.

A sticky overflow flag records any combination whose exact value leaves the signed 32-bit range. Only a synchronous clear input brings the flag back to zero. The result is not saturated: it wraps modulo 2^32.

Top module: `dual_hw_mac`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid`, `result` and `ovf_sticky` are all 0 after that edge.
- R2: With `xchg`=0, the products are a.lo*b.lo and a.hi*b.hi. Here lo means bits 15:0 and hi means bits 31:16, and each is read as two's-complement.
- R3: With `xchg`=1, the products are a.lo*b.hi and a.hi*b.lo.
- R4: With `mode_sub`=0, `result` is the sum of the two products modulo 2^32. The result is never saturated.
- R5: With `mode_sub`=1, `result` is the low-lane product minus the high-lane product, modulo 2^32.
- R6: An accepted sum-mode operation whose exact sum exceeds 2^31-1 sets `ovf_sticky` to 1 at the same edge that registers `result`. The only such case is all four multiplied halfwords equal to -32768, which gives result 0x80000000.
- R7: Once set, `ovf_sticky` stays 1 through any later operations until it is cleared.
- R8: `flag_clr`=1 at a clock edge clears `ovf_sticky`. If an accepted overflowing operation occurs at the same edge, the set wins.
- R9: An operation in difference mode never sets `ovf_sticky`, including when every halfword is -32768.
- R10: `out_valid` equals `in_valid` delayed by one cycle. Back-to-back operations each produce their own result on consecutive cycles.
- R11: When `in_valid`=0, `result` holds its previous value and `ovf_sticky` is not set, even if the operands would overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation request strobe |
| op_a | input | 32 | First packed-halfword operand |
| op_b | input | 32 | Second packed-halfword operand |
| mode_sub | input | 1 | 0 = sum of products, 1 = low minus high |
| xchg | input | 1 | 1 = swap halfwords of op_b before multiplying |
| flag_clr | input | 1 | Synchronous clear of the sticky overflow flag |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| result | output | 32 | Registered combined result |
| ovf_sticky | output | 1 | Sticky overflow flag |

## Verification
The assertions assume that every input is a known 0 or 1 on every clock edge once reset is released. They also assume that `flag_clr` is the only thing that lowers the flag other than reset. The bench changes all inputs on the falling edge, keeps `in_valid`, `mode_sub`, `xchg` and `flag_clr` at defined values at all times, and idles with `in_valid`=0 between scenarios. The overflow corner is reached deliberately with all-(-32768) operands in both modes, with and without the strobe, and together with a clear.

// File: rtl/dual_hw_mac_pkg.sv
package dual_hw_mac_pkg;

    localparam int HALF_W = 16;
    localparam int WORD_W = 2 * HALF_W;
    localparam int PROD_W = 2 * HALF_W;
    localparam int EXT_W  = PROD_W + 1;

    typedef logic signed [HALF_W-1:0] half_t;
    typedef logic signed [PROD_W-1:0] prod_t;
    typedef logic signed [EXT_W-1:0]  ext_t;

    typedef struct packed {
        half_t hi;
        half_t lo;
    } pair_t;

    typedef enum logic {
        COMB_SUM  = 1'b0,
        COMB_DIFF = 1'b1
    } combine_e;

    function automatic pair_t swap_halves(input pair_t p);
        pair_t r;
        r.hi = p.lo;
        r.lo = p.hi;
        return r;
    endfunction

    function automatic ext_t sign_extend(input prod_t p);
        return {p[PROD_W-1], p};
    endfunction

endpackage

// File: rtl/hw_product_pair.sv
module hw_product_pair
    import dual_hw_mac_pkg::*;
(
    input  pair_t a,
    input  pair_t b,
    input  logic  xchg,
    output prod_t p_lo,
    output prod_t p_hi
);
    localparam int LANES = 2;

    pair_t b_sel;
    half_t a_lane [LANES];
    half_t b_lane [LANES];
    prod_t p_lane [LANES];

    assign b_sel     = xchg ? swap_halves(b) : b;
    assign a_lane[0] = a.lo;
    assign a_lane[1] = a.hi;
    assign b_lane[0] = b_sel.lo;
    assign b_lane[1] = b_sel.hi;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign p_lane[i] = a_lane[i] * b_lane[i];
    end

    assign p_lo = p_lane[0];
    assign p_hi = p_lane[1];
endmodule

// File: rtl/product_combiner.sv
module product_combiner
    import dual_hw_mac_pkg::*;
(
    input  prod_t    p_lo,
    input  prod_t    p_hi,
    input  combine_e how,
    output logic [WORD_W-1:0] word,
    output logic     ovf
);
    ext_t lo_x, hi_x, exact;

    assign lo_x  = sign_extend(p_lo);
    assign hi_x  = sign_extend(p_hi);
    assign exact = (how == COMB_DIFF) ? (lo_x - hi_x) : (lo_x + hi_x);
    assign word  = exact[WORD_W-1:0];
    assign ovf   = exact[EXT_W-1] ^ exact[EXT_W-2];
endmodule

// File: rtl/dual_hw_mac.sv
module dual_hw_mac
    import dual_hw_mac_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [31:0] op_a,
    input  logic [31:0] op_b,
    input  logic        mode_sub,
    input  logic        xchg,
    input  logic        flag_clr,
    output logic        out_valid,
    output logic [31:0] result,
    output logic        ovf_sticky
);
    prod_t              p_lo, p_hi;
    logic [WORD_W-1:0]  comb_word;
    logic               comb_ovf;
    combine_e           how;

    assign how = mode_sub ? COMB_DIFF : COMB_SUM;

    hw_product_pair u_prod (
        .a    (pair_t'(op_a)),
        .b    (pair_t'(op_b)),
        .xchg (xchg),
        .p_lo (p_lo),
        .p_hi (p_hi)
    );

    product_combiner u_comb (
        .p_lo (p_lo),
        .p_hi (p_hi),
        .how  (how),
        .word (comb_word),
        .ovf  (comb_ovf)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            result     <= '0;
            ovf_sticky <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                result <= comb_word;
            if (in_valid && comb_ovf)
                ovf_sticky <= 1'b1;
            else if (flag_clr)
                ovf_sticky <= 1'b0;
        end
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R10
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R10
    AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (ovf_sticky && !flag_clr) |=> ovf_sticky); // R7
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && !(in_valid && comb_ovf)) |=> !ovf_sticky); // R8
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode_sub && !ovf_sticky) |=> !ovf_sticky); // R9
    AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result)); // R11
    AST_IDLE_NO_SET: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !ovf_sticky) |=> !ovf_sticky); // R11
endmodule

// File: tb/dual_hw_mac_tb.sv
module dual_hw_mac_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, mode_sub, xchg, flag_clr;
    logic [31:0] op_a, op_b;
    logic        out_valid, ovf_sticky;
    logic [31:0] result;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    dual_hw_mac u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .mode_sub(mode_sub), .xchg(xchg), .flag_clr(flag_clr),
        .out_valid(out_valid), .result(result), .ovf_sticky(ovf_sticky)
    );

    function automatic longint exact_val(input logic [31:0] a, input logic [31:0] b,
                                         input bit sub, input bit x);
        longint al, ah, bl, bh, p0, p1;
        al = longint'($signed(a[15:0]));
        ah = longint'($signed(a[31:16]));
        bl = x ? longint'($signed(b[31:16])) : longint'($signed(b[15:0]));
        bh = x ? longint'($signed(b[15:0]))  : longint'($signed(b[31:16]));
        p0 = al * bl;
        p1 = ah * bh;
        return sub ? (p0 - p1) : (p0 + p1);
    endfunction

    function automatic bit out_of_range(input longint v);
        return (v > 64'sd2147483647) || (v < -64'sd2147483648);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input bit v, input logic [31:0] a, input logic [31:0] b,
                         input bit sub, input bit x, input bit clr);
        in_valid = v; op_a = a; op_b = b; mode_sub = sub; xchg = x; flag_clr = clr;
    endtask

    task automatic idle();
        drive(0, 32'h0, 32'h0, 0, 0, 0);
    endtask

    // one accepted operation, result checked one cycle later
    task automatic op_check(input string req, input logic [31:0] a, input logic [31:0] b,
                            input bit sub, input bit x);
        longint e;
        e = exact_val(a, b, sub, x);
        drive(1, a, b, sub, x, 0);
        @(negedge clk);
        idle();
        chk(req, result, e[31:0]);
        chk("R10", {31'b0, out_valid}, 32'd1);
    endtask

    task automatic t_reset();
        rst = 1; idle();
        repeat (3) @(negedge clk);
        chk("R1", {31'b0, out_valid}, 32'd0);
        chk("R1", result, 32'd0);
        chk("R1", {31'b0, ovf_sticky}, 32'd0);
        rst = 0;
        @(negedge clk);
    endtask

    task automatic t_straight();
        op_check("R2", 32'h0003_FFFE, 32'h0005_0007, 0, 0);
        op_check("R2", 32'h7FFF_8001, 32'h1234_FEDC, 0, 0);
        op_check("R4", 32'h7FFF_7FFF, 32'h7FFF_7FFF, 0, 0);
    endtask

    task automatic t_exchange();
        op_check("R3", 32'h0003_FFFE, 32'h0005_0007, 0, 1);
        op_check("R3", 32'hABCD_0102, 32'h8000_7FFF, 0, 1);
        op_check("R3", 32'h0010_0001, 32'h0002_0300, 1, 1);
    endtask

    task automatic t_subtract();
        op_check("R5", 32'h0003_FFFE, 32'h0005_0007, 1, 0);
        op_check("R5", 32'h8000_7FFF, 32'h7FFF_8000, 1, 0);
        chk("R9", {31'b0, ovf_sticky}, 32'd0);
    endtask

    task automatic t_sub_extreme();
        op_check("R9", 32'h8000_8000, 32'h8000_8000, 1, 0);
        chk("R9", {31'b0, ovf_sticky}, 32'd0);
        op_check("R9", 32'h8000_8000, 32'h8000_8000, 1, 1);
        chk("R9", {31'b0, ovf_sticky}, 32'd0);
    endtask

    task automatic t_idle_no_effect();
        logic [31:0] held;
        held = result;
        drive(0, 32'h8000_8000, 32'h8000_8000, 0, 0, 0);
        repeat (2) @(negedge clk);
        chk("R11", result, held);
        chk("R11", {31'b0, ovf_sticky}, 32'd0);
        chk("R10", {31'b0, out_valid}, 32'd0);
        idle();
    endtask

    task automatic t_overflow();
        longint e;
        e = exact_val(32'h8000_8000, 32'h8000_8000, 0, 0);
        chk("R6", {31'b0, out_of_range(e)}, 32'd1);
        op_check("R6", 32'h8000_8000, 32'h8000_8000, 0, 0);
        chk("R6", result, 32'h8000_0000);
        chk("R6", {31'b0, ovf_sticky}, 32'd1);
    endtask

    task automatic t_sticky();
        op_check("R7", 32'h0001_0001, 32'h0001_0001, 0, 0);
        chk("R7", {31'b0, ovf_sticky}, 32'd1);
        op_check("R7", 32'h0002_0003, 32'h0004_0005, 1, 1);
        chk("R7", {31'b0, ovf_sticky}, 32'd1);
    endtask

    task automatic t_clear();
        drive(0, 32'h0, 32'h0, 0, 0, 1);
        @(negedge clk);
        idle();
        chk("R8", {31'b0, ovf_sticky}, 32'd0);
        // clear together with an overflowing accepted operation: set wins
        drive(1, 32'h8000_8000, 32'h8000_8000, 0, 1, 1);
        @(negedge clk);
        idle();
        chk("R8", {31'b0, ovf_sticky}, 32'd1);
        drive(0, 32'h0, 32'h0, 0, 0, 1);
        @(negedge clk);
        idle();
        chk("R8", {31'b0, ovf_sticky}, 32'd0);
    endtask

    task automatic t_back_to_back();
        logic [31:0] a_v [4] = '{32'h1111_2222, 32'hFFFF_0001, 32'h7FFF_8000, 32'h0100_FF00};
        logic [31:0] b_v [4] = '{32'h3333_4444, 32'h0002_FFFF, 32'h0003_0004, 32'hF00D_BEEF};
        bit          s_v [4] = '{0, 1, 0, 1};
        bit          x_v [4] = '{0, 0, 1, 1};
        for (int i = 0; i < 4; i++) begin
            longint e;
            drive(1, a_v[i], b_v[i], s_v[i], x_v[i], 0);
            @(negedge clk);
            e = exact_val(a_v[i], b_v[i], s_v[i], x_v[i]);
            chk("R10", result, e[31:0]);
            chk("R10", {31'b0, out_valid}, 32'd1);
        end
        idle();
        @(negedge clk);
        chk("R10", {31'b0, out_valid}, 32'd0);
    endtask

    initial begin
        t_reset();
        t_straight();
        t_exchange();
        t_subtract();
        t_sub_extreme();
        t_idle_no_effect();
        t_overflow();
        t_sticky();
        t_clear();
        t_back_to_back();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule